// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Controller

This block merges the interrupt request lines of several peripherals into one interrupt output for a processor. Each request line first passes through a two-flop synchronizer. The line can then be used in one of two ways. A level line follows its input. An edge line captures a rising transition, but only while the line is enabled.

The processor configures and services the lines through a four-word register port. The port is synchronous for writes, and read data follows the address combinationally. The processor can:
- mask or unmask each line,
- select the trigger mode of each line,
- read which lines are pending,
- acknowledge lines by writing ones.

The processor output is a registered OR over every line that is pending and not masked.

Masking, unmasking and acknowledging act differently on the two kinds of line:
- An edge that arrives while its line is masked is dropped.
- A level that is held while its line is masked is reported as soon as the mask opens.
- Acknowledging an edge line removes its request.
- Acknowledging a level line whose input is still high removes the request for a single cycle only, after which the request returns.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset the mask word reads all ones, the mode word reads all zeros (level), the pending word reads zero and `irq_out` is low.
- R2: Offset 0 holds the mask (bit i = 1 masks line i) and offset 1 holds the mode (bit i = 1 selects edge). Both read back what was written. Offset 2 returns the pending bits, and writes to offset 2 change nothing. Offset 3 reads as zero.
- R3: While every line is masked, `irq_out` stays low.
- R4: A rising input on an unmasked line raises `irq_out` four clock edges after the input changes, in either mode. The four edges are two synchronizer stages, the pending register and the output register.
- R5: A level line whose input is high shows as pending even while masked. Clearing its mask bit raises `irq_out` on the clock edge that follows the mask write.
- R6: An edge line that rises while masked does not become pending. Unmasking it later leaves `irq_out` low.
- R7: When an input falls from high to low, that line's pending bit clears and its contribution to `irq_out` goes away, in both modes.
- R8: Writing a one at offset 3 for a pending edge line clears its pending bit. `irq_out` then falls one cycle later if no other line is active.
- R9: Writing a one at offset 3 for a level line whose input is still high clears its pending bit for one cycle only. `irq_out` is low for exactly one cycle and then high again.
- R10: If a rising edge of an unmasked edge line and the acknowledge of that same line land in the same cycle, the line stays pending.
- R11: `irq_out` is high exactly when, one cycle earlier, some line was both pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Asynchronous request lines from the peripherals |
| reg_addr | input | 2 | Register word offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | NUM_LINES | Write data, one bit per line |
| reg_rdata | output | NUM_LINES | Read data for the word at `reg_addr` |
| irq_out | output | 1 | Merged interrupt output to the processor |

## Verification
A fresh rising edge of an edge line can reach the pending logic in the same cycle as a processor acknowledge of that line. Each of the two wants the pending bit to go the opposite way.

The bench provokes the collision by counting clock edges. It raises the input, waits two edges for the synchronizer, and then holds the acknowledge write exactly across the edge on which the rising edge is detected. The outcome is judged through the pending word and `irq_out`, which must both still show the line as active.

The level-line acknowledge, where the still-high input immediately sets the bit again, is judged edge by edge. The check looks for the one-cycle dip on `irq_out`.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  typedef enum logic [1:0] {
    OFS_MASK = 2'd0,
    OFS_MODE = 2'd1,
    OFS_PEND = 2'd2,
    OFS_ACK  = 2'd3
  } reg_ofs_e;

  // Per-line control bundle handed from the register bank to a line cell.
  typedef struct packed {
    logic masked;
    logic edge_mode;
    logic ack;
  } line_ctl_t;

  localparam int unsigned SYNC_STAGES = 2;

  // Next value of one line's pending bit.
  // Edge: a new enabled edge sets it (and beats an acknowledge); otherwise
  // it is held while the input stays high and no acknowledge arrives.
  // Level: it mirrors the input, except for the acknowledge cycle.
  function automatic logic pend_next(line_ctl_t c, logic pend, logic lvl, logic rise);
    if (c.edge_mode)
      return (rise & ~c.masked) | (pend & lvl & ~c.ack);
    return lvl & ~c.ack;
  endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned STAGES    = irq_merge_pkg::SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] async_in,
  output logic [NUM_LINES-1:0] sync_out
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else if (STAGES == 1) chain <= async_in[i];
      else chain <= {chain[STAGES-2:0], async_in[i]};
    end

    assign sync_out[i] = chain[LAST];
  end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_merge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  line_ctl_t ctl,
  output logic      pend,
  output logic      rise
);

  logic lvl_prev;
  logic pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  // Named event: a rising edge of the synchronized input, seen once.
  assign rise   = lvl & ~lvl_prev;
  assign pend_d = pend_next(ctl, pend, lvl, rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // R5: a held level is recorded whether or not the line is masked
  p_level_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.edge_mode && lvl && !ctl.ack) |=> pend);

  // R6: a masked edge line that is idle stays idle
  p_masked_edge_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.edge_mode && ctl.masked && !pend) |=> !pend);

  // R7: a falling input removes the request in either mode
  p_fall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl) |=> !pend);

  // R8: acknowledge of an edge line without a new edge drops it
  p_edge_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.edge_mode && ctl.ack && !rise) |=> !pend);

  // R9: acknowledge of a level line clears it for the next cycle
  p_level_ack_dip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.edge_mode && ctl.ack) |=> !pend);

  // R10: a new enabled edge wins over a same-cycle acknowledge
  p_edge_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.edge_mode && rise && !ctl.masked) |=> pend);

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_merge_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  input  logic [NUM_LINES-1:0] pend_in,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] mode_q,
  output logic [NUM_LINES-1:0] ack_pulse
);

  reg_ofs_e ofs;
  logic     wr_mask, wr_mode, wr_ack;

  assign ofs     = reg_ofs_e'(reg_addr);
  assign wr_mask = reg_wr && (ofs == OFS_MASK);
  assign wr_mode = reg_wr && (ofs == OFS_MODE);
  assign wr_ack  = reg_wr && (ofs == OFS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata;
      if (wr_mode) mode_q <= reg_wdata;
    end
  end

  assign ack_pulse = wr_ack ? reg_wdata : '0;

  always_comb begin
    unique case (ofs)
      OFS_MASK: reg_rdata = mask_q;
      OFS_MODE: reg_rdata = mode_q;
      OFS_PEND: reg_rdata = pend_in;
      default:  reg_rdata = '0;
    endcase
  end

  // R2: the status word is read-only
  p_pend_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ofs == OFS_PEND) |=> ($stable(mask_q) && $stable(mode_q)));

  // R2: an acknowledge write leaves configuration untouched
  p_ack_keeps_config_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ofs == OFS_ACK) |=> ($stable(mask_q) && $stable(mode_q)));

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import irq_merge_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 irq_out
);

  logic [NUM_LINES-1:0] lvl_sync;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] ack_pulse;
  logic                 any_active;
  logic                 irq_q;

  function automatic logic any_enabled(logic [NUM_LINES-1:0] p, logic [NUM_LINES-1:0] m);
    return |(p & ~m);
  endfunction

  irq_sync_bank #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (lvl_sync)
  );

  irq_reg_bank #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend_in   (pend),
    .reg_rdata (reg_rdata),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .ack_pulse (ack_pulse)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cell
    line_ctl_t ctl;
    assign ctl.masked    = mask_q[i];
    assign ctl.edge_mode = mode_q[i];
    assign ctl.ack       = ack_pulse[i];

    irq_line_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_sync[i]),
      .ctl   (ctl),
      .pend  (pend[i]),
      .rise  (rise[i])
    );
  end

  assign any_active = any_enabled(pend, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_active;
  end

  assign irq_out = irq_q;

  // R3: with every line masked the processor sees nothing
  p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_out);

  // R4: an enabled edge detection leads to the output two edges later
  p_rise_reaches_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & mode_q & ~mask_q)) |=> ##1 (irq_out || $past(|mask_q & ~$past(mask_q))));

  // R11: no pending-and-enabled line means a low output next cycle
  p_idle_means_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & ~mask_q)) |=> !irq_out);

endmodule

// File: tb/irq_merge_ctrl_test.sv
module irq_merge_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [1:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_merge_ctrl #(.NUM_LINES(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector: {mask, mode, lines}; lines rise from zero after configuration.
  localparam logic [3*N-1:0] VECS [6] = '{
    {8'hFF, 8'h00, 8'hFF},
    {8'h00, 8'h00, 8'h01},
    {8'hF0, 8'hFF, 8'h0F},
    {8'h0F, 8'hFF, 8'h0F},
    {8'hAA, 8'h55, 8'hFF},
    {8'h00, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    irq_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;

    // R1: reset state
    do_reset();
    rd(2'd0, d); check("R1 mask", d, '1);
    rd(2'd1, d); check("R1 mode", d, '0);
    rd(2'd2, d); check("R1 pend", d, '0);
    check("R1 irq", {7'd0, irq_out}, 8'd0);

    // R2: readback and read-only words
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hFF);
    rd(2'd0, d); check("R2 mask readback", d, 8'hA5);
    rd(2'd1, d); check("R2 mode readback", d, 8'h3C);
    rd(2'd2, d); check("R2 pend read-only", d, 8'h00);
    rd(2'd3, d); check("R2 ack reads zero", d, 8'h00);

    // Table walk: R3, R5, R6, R11
    for (int v = 0; v < 6; v++) begin
      logic [N-1:0] m, md, ln, ep;
      logic e_irq;
      {m, md, ln} = VECS[v];
      do_reset();
      wr(2'd1, md);
      wr(2'd0, m);
      @(negedge clk); irq_in = ln;
      repeat (6) @(negedge clk);
      ep = 0;
      for (int b = 0; b < N; b++)
        if (ln[b] && (!md[b] || !m[b])) ep[b] = 1'b1;
      e_irq = 1'b0;
      for (int b = 0; b < N; b++)
        if (ep[b] && !m[b]) e_irq = 1'b1;
      rd(2'd2, d); check($sformatf("R5 R6 table %0d pend", v), d, ep);
      check($sformatf("R3 R11 table %0d irq", v), {7'd0, irq_out}, {7'd0, e_irq});
    end

    // R4: four-edge latency, edge mode
    do_reset();
    wr(2'd1, 8'h20); wr(2'd0, 8'hDF);
    @(negedge clk); irq_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 not yet", {7'd0, irq_out}, 8'd0);
    @(negedge clk);
    check("R4 asserted edge", {7'd0, irq_out}, 8'd1);

    // R4: four-edge latency, level mode
    do_reset();
    wr(2'd0, 8'hFE);
    @(negedge clk); irq_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 level not yet", {7'd0, irq_out}, 8'd0);
    @(negedge clk);
    check("R4 asserted level", {7'd0, irq_out}, 8'd1);

    // R5: level held while masked, then unmasked
    do_reset();
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 masked quiet", {7'd0, irq_out}, 8'd0);
    wr(2'd0, 8'hF7);
    check("R5 before edge", {7'd0, irq_out}, 8'd0);
    @(negedge clk);
    check("R5 asserts on unmask", {7'd0, irq_out}, 8'd1);

    // R7: falling input removes it
    irq_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 irq falls", {7'd0, irq_out}, 8'd0);
    rd(2'd2, d); check("R7 pend cleared", d, 8'h00);

    // R6: edge rose while masked
    do_reset();
    wr(2'd1, 8'h10);
    @(negedge clk); irq_in[4] = 1'b1;
    repeat (5) @(negedge clk);
    wr(2'd0, 8'hEF);
    repeat (3) @(negedge clk);
    check("R6 no irq after unmask", {7'd0, irq_out}, 8'd0);

    // R8: acknowledge an edge line
    do_reset();
    wr(2'd1, 8'h02); wr(2'd0, 8'hFD);
    @(negedge clk); irq_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 raised", {7'd0, irq_out}, 8'd1);
    wr(2'd3, 8'h02);
    @(negedge clk);
    check("R8 irq dropped", {7'd0, irq_out}, 8'd0);
    rd(2'd2, d); check("R8 pend dropped", d, 8'h00);

    // R9: acknowledge a level line still high
    do_reset();
    wr(2'd0, 8'hFE);
    @(negedge clk); irq_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    wr(2'd3, 8'h01);
    @(negedge clk);
    check("R9 dip", {7'd0, irq_out}, 8'd0);
    @(negedge clk);
    check("R9 back high", {7'd0, irq_out}, 8'd1);

    // R10: edge detection and acknowledge in the same cycle
    do_reset();
    wr(2'd1, 8'h04); wr(2'd0, 8'hFB);
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = 8'h04; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd2, d); check("R10 stays pending", d, 8'h04);
    check("R10 irq high", {7'd0, irq_out}, 8'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule